// File: doc/BRIEF.md
# MAC Port Interrupt Controller

This block gathers interrupt events from one MAC port into an eight-bit raw status register and drives a single interrupt line. Each raw bit is set by a one-cycle event pulse and stays set until software writes a one to that bit. Four of the sources have fixed meanings: bit 0 is receive-ready, bit 1 is transmit-done for each packet, bit 6 is transmit-queue-empty, and bit 7 is receive-ready for several frames. The remaining bits are general event inputs.

The interrupt reaches the output only through two levels of gating. First, each source has its own enable bit. Second, a port enable and a global enable must both be set. A masked status view is readable, so software sees exactly the sources that are currently driving the line. Receive-ready also has a level input that shows frames are still waiting. While that input is high, the receive-ready bit sets again on every cycle, so clearing it cannot hide a backlog. Software uses a simple address/data port with a write strobe, and reads are combinational from the address.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After reset the raw register, the enable register, the status view and `irq_o` all read zero.
- R2: A pulse on `evt_i[k]` sets raw bit k at the next clock edge. The bit stays set until it is cleared by a write.
- R3: A write to the raw offset 0x38 clears exactly the raw bits whose `wdata_i[7:0]` bits are 1 and leaves the other bits alone. The value 0xFF clears every source.
- R4: When an event and a write-one-to-clear reach the same raw bit at the same edge, the bit ends up set.
- R5: While `rx_backlog_i` is high, raw bit 0 (receive-ready) is set at every edge, so a clear during a backlog leaves it set.
- R6: A write to the enable offset 0x34 stores `wdata_i` bits 7:0 (per-source enables), bit 18 (port enable) and bit 19 (global enable). Reading that offset returns the stored bits, and every other bit reads 0.
- R7: Reading the status offset 0x30 returns raw AND enable[7:0] when enable bits 18 and 19 are both 1, and returns 0 otherwise.
- R8: `irq_o` is high exactly when the status view is nonzero.
- R9: Clearing either the port enable or the global enable forces `irq_o` low, even while enabled raw bits are set.
- R10: Writes to the status offset or to any unmapped offset change no state, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | One-cycle event pulses, one per raw bit |
| rx_backlog_i | input | 1 | High while received frames are still pending |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
Every state change takes effect at the clock edge where the event, backlog level or write strobe is sampled. The raw, enable and status values, and `irq_o`, are therefore due one edge after the stimulus, and reads show them with no further delay. The bench applies its stimulus just after a falling edge and updates its reference model at the rising edge. At the next falling edge it compares `irq_o` and reads all three offsets plus one unmapped offset, so each result is checked in the first cycle in which it is due.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int unsigned SRC_N        = 8;
  localparam int unsigned RX_RDY_BIT   = 0;
  localparam int unsigned TX_PKT_BIT   = 1;
  localparam int unsigned TX_EMPTY_BIT = 6;
  localparam int unsigned RX_MULTI_BIT = 7;
  localparam int unsigned PORT_EN_BIT  = 18;
  localparam int unsigned GLB_EN_BIT   = 19;
  localparam logic [7:0]  STAT_OFF     = 8'h30;
  localparam logic [7:0]  ENA_OFF      = 8'h34;
  localparam logic [7:0]  RAW_OFF      = 8'h38;
endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
  parameter int unsigned SRC_N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] raw_o
);
  for (genvar g = 0; g < SRC_N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        bit_q <= 1'b0;
      else if (set_i[g])  bit_q <= 1'b1;  // set beats clear
      else if (clr_i[g])  bit_q <= 1'b0;
    end
    assign raw_o[g] = bit_q;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SRC_N    = 8,
  parameter int unsigned PORT_BIT = 18,
  parameter int unsigned GLB_BIT  = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic [SRC_N-1:0]  src_en_o,
  output logic              port_en_o,
  output logic              glb_en_o
);
  localparam logic [DATA_W-1:0] SRC_MASK  = {{(DATA_W-SRC_N){1'b0}}, {SRC_N{1'b1}}};
  localparam logic [DATA_W-1:0] KEEP_MASK = SRC_MASK
                                          | (DATA_W'(1) << PORT_BIT)
                                          | (DATA_W'(1) << GLB_BIT);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (wr_i) word_q <= wdata_i & KEEP_MASK;
  end

  assign word_o    = word_q;
  assign src_en_o  = word_q[SRC_N-1:0];
  assign port_en_o = word_q[PORT_BIT];
  assign glb_en_o  = word_q[GLB_BIT];
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SRC_N    = 8,
  parameter logic [ADDR_W-1:0] STAT_OFF = 8'h30,
  parameter logic [ADDR_W-1:0] ENA_OFF  = 8'h34,
  parameter logic [ADDR_W-1:0] RAW_OFF  = 8'h38
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SRC_N-1:0]  raw_i,
  input  logic [SRC_N-1:0]  stat_i,
  input  logic [DATA_W-1:0] ena_word_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    case (addr_i)
      STAT_OFF: rdata_o = {{(DATA_W-SRC_N){1'b0}}, stat_i};
      ENA_OFF:  rdata_o = ena_word_i;
      RAW_OFF:  rdata_o = {{(DATA_W-SRC_N){1'b0}}, raw_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SRC_N      = mac_irq_pkg::SRC_N,
  parameter int unsigned RX_RDY_BIT = mac_irq_pkg::RX_RDY_BIT,
  parameter int unsigned PORT_BIT   = mac_irq_pkg::PORT_EN_BIT,
  parameter int unsigned GLB_BIT    = mac_irq_pkg::GLB_EN_BIT,
  parameter logic [ADDR_W-1:0] STAT_OFF = mac_irq_pkg::STAT_OFF,
  parameter logic [ADDR_W-1:0] ENA_OFF  = mac_irq_pkg::ENA_OFF,
  parameter logic [ADDR_W-1:0] RAW_OFF  = mac_irq_pkg::RAW_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              rx_backlog_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              wr_raw, wr_ena;
  logic [SRC_N-1:0]  set_vec, clr_vec, raw_q, src_en, stat_vec;
  logic [DATA_W-1:0] en_word;
  logic              port_en, glb_en;

  assign wr_raw  = wr_en_i && (addr_i == RAW_OFF);
  assign wr_ena  = wr_en_i && (addr_i == ENA_OFF);
  assign clr_vec = wr_raw ? wdata_i[SRC_N-1:0] : '0;
  // backlog level re-asserts receive-ready every cycle
  assign set_vec = evt_i | (SRC_N'(rx_backlog_i) << RX_RDY_BIT);

  irq_raw_bank #(.SRC_N(SRC_N)) u_raw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .raw_o  (raw_q)
  );

  irq_enable_reg #(
    .DATA_W(DATA_W), .SRC_N(SRC_N), .PORT_BIT(PORT_BIT), .GLB_BIT(GLB_BIT)
  ) u_ena (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ena),
    .wdata_i   (wdata_i),
    .word_o    (en_word),
    .src_en_o  (src_en),
    .port_en_o (port_en),
    .glb_en_o  (glb_en)
  );

  assign stat_vec = (port_en && glb_en) ? (raw_q & src_en) : '0;
  assign irq_o    = |stat_vec;

  irq_read_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_N(SRC_N),
    .STAT_OFF(STAT_OFF), .ENA_OFF(ENA_OFF), .RAW_OFF(RAW_OFF)
  ) u_rd (
    .addr_i     (addr_i),
    .raw_i      (raw_q),
    .stat_i     (stat_vec),
    .ena_word_i (en_word),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SRC_N  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SRC_N-1:0]  evt_i,
  input logic              rx_backlog_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [SRC_N-1:0]  raw_q,
  input logic [DATA_W-1:0] en_word
);
  localparam logic [ADDR_W-1:0] ENA_A = ADDR_W'(mac_irq_pkg::ENA_OFF);
  localparam logic [ADDR_W-1:0] RAW_A = ADDR_W'(mac_irq_pkg::RAW_OFF);
  localparam int unsigned PB = mac_irq_pkg::PORT_EN_BIT;
  localparam int unsigned GB = mac_irq_pkg::GLB_EN_BIT;

  // R2 and R4: every pulsed bit is set after the edge, clear or not
  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RAW_A && ((wdata_i[SRC_N-1:0] & evt_i) != '0))
    |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R3: clear without competing sets removes exactly the written ones
  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RAW_A && evt_i == '0 && !rx_backlog_i)
    |=> (raw_q == ($past(raw_q) & ~$past(wdata_i[SRC_N-1:0]))));

  // R5: backlog keeps receive-ready set
  a_r5_backlog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_backlog_i |=> raw_q[0]);

  // R9: no interrupt without both upper gates
  a_r9_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_word[PB] && en_word[GB]));

  // R8: an enabled, gated source raises the line
  a_r8_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((raw_q & en_word[SRC_N-1:0]) != '0) && en_word[PB] && en_word[GB]) |-> irq_o);

  // R10: writes elsewhere leave enable and raw alone
  a_r10_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != ENA_A && addr_i != RAW_A && evt_i == '0 && !rx_backlog_i)
    |=> ($stable(raw_q) && $stable(en_word)));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_N(SRC_N)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_i        (evt_i),
  .rx_backlog_i (rx_backlog_i),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .irq_o        (irq_o),
  .raw_q        (raw_q),
  .en_word      (en_word)
);

// File: tb/mac_irq_ctrl_test.sv
`timescale 1ns/1ps
module mac_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        rx_backlog_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  mac_irq_ctrl uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  int m_raw = 0;
  int m_en = 0;

  function automatic int m_stat();
    if (m_en[18] && m_en[19]) return m_raw & m_en & 'hFF;
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check({req, " irq"}, {31'd0, irq_o}, (m_stat() != 0) ? 32'd1 : 32'd0);
    addr_i = 8'h38; #1; check({req, " raw"}, rdata_o, m_raw);
    addr_i = 8'h34; #1; check({req, " ena"}, rdata_o, m_en);
    addr_i = 8'h30; #1; check({req, " stat"}, rdata_o, m_stat());
    addr_i = 8'h3C; #1; check({req, " unmapped R10"}, rdata_o, 32'd0);
  endtask

  task automatic step(input string req, input logic [7:0] evt, input logic bl,
                      input logic wr, input logic [7:0] a, input logic [31:0] d);
    int clr;
    evt_i = evt; rx_backlog_i = bl; wr_en_i = wr; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    clr = (wr && a == 8'h38) ? (d & 'hFF) : 0;
    m_raw = (m_raw & ~clr) | evt | (bl ? 1 : 0);
    if (wr && a == 8'h34) m_en = d & 'h000C_00FF;
    @(negedge clk_i);
    evt_i = '0; rx_backlog_i = 1'b0; wr_en_i = 1'b0;
    compare_all(req);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    compare_all("R1 reset");
    #45 rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R1 after release");
    // R2: single pulses, nothing enabled
    step("R2 bit1", 8'h02, 0, 0, 0, 0);
    step("R2 hold", 8'h00, 0, 0, 0, 0);
    step("R2 bit6,7", 8'hC0, 0, 0, 0, 0);
    // R6: enable readback with junk bits
    step("R6 ena junk", 0, 0, 1, 8'h34, 32'hFFFF_FFFF);
    step("R6 ena src only", 0, 0, 1, 8'h34, 32'h0000_0042);
    // R7/R9: port only, then global only, then both
    step("R9 port only", 0, 0, 1, 8'h34, 32'h0004_00FF);
    step("R9 glb only", 0, 0, 1, 8'h34, 32'h0008_00FF);
    step("R7 R8 both", 0, 0, 1, 8'h34, 32'h000C_0040);
    step("R8 partial mask", 0, 0, 1, 8'h34, 32'h000C_0001);
    // R3: clear a subset
    step("R3 clear bit6", 0, 0, 1, 8'h38, 32'h0000_0040);
    step("R3 zero write", 0, 0, 1, 8'h38, 32'h0000_0000);
    step("R3 all events", 8'hFF, 0, 0, 0, 0);
    step("R3 clear FF", 0, 0, 1, 8'h38, 32'h0000_00FF);
    // R4: set and clear together
    step("R4 prep", 8'h01, 0, 0, 0, 0);
    step("R4 collide", 8'h81, 0, 1, 8'h38, 32'h0000_0081);
    step("R4 clear", 0, 0, 1, 8'h38, 32'h0000_00FF);
    // R5: backlog
    step("R5 backlog set", 0, 1, 0, 0, 0);
    step("R5 clear in backlog", 0, 1, 1, 8'h38, 32'h0000_0001);
    step("R5 backlog over", 0, 0, 1, 8'h38, 32'h0000_0001);
    // R10: writes to status and unmapped offsets
    step("R10 prep", 8'h24, 0, 1, 8'h34, 32'h000C_00FF);
    step("R10 stat write", 0, 0, 1, 8'h30, 32'hFFFF_FFFF);
    step("R10 unmapped write", 0, 0, 1, 8'h3C, 32'h0000_0000);
    step("R9 global off", 0, 0, 1, 8'h34, 32'h0004_00FF);
    step("R8 back on", 0, 0, 1, 8'h34, 32'h000C_0004);
    for (int i = 0; i < 8; i++) begin
      step("R2 walk", 8'(1 << i), 0, 0, 0, 0);
      step("R3 walk clr", 0, 0, 1, 8'h38, 32'(1 << i));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule